// File: doc/BRIEF.md
# Low-Power Mode Register Controller

This block holds the control side of the power-saving logic for a 1M x 16 pseudo-static RAM. The host programs a small mode register with an ordinary write cycle, issued while the active-low sleep pin is held low. The code is taken from the five lowest address pins, and the data bus plays no part. The value is held as pending and becomes the committed register only when the sleep pin returns high.

Once a value is committed, the next time the sleep pin goes low without a register write in the first microsecond, the block enters one of three modes. The mode is deep power down, partial array refresh, or reduced memory size. The block reports the word-address window whose contents are kept, a data-retained flag, a deep-power-down flag and a busy flag. Busy covers the power-up wait and the recovery after deep power down. Sticky flags report protocol errors and the use of the reserved area code. All timing is counted in clock cycles through `CLK_PER_US`.

Top module: `lp_mode_ctrl`

## Requirements
- R1: After reset, `busy` is high for exactly PWRUP_US*CLK_PER_US cycles. The window reads 0 to all-ones, `dataRetained` is 1, and `deepPd`, `protoErr` and `rsvdWarn` are 0.
- R2: An access (`chipSelN` low with at least one byte enable low) or a low `sleepN` while `busy` is high sets the sticky `protoErr`.
- R3: A register write is a cycle with `chipSelN` and `wrEnN` low and at least one byte enable low, sampled while `sleepN` is low. It must begin in the same cycle as the fall of `sleepN` or within ZZWE_US*CLK_PER_US cycles after it. The code is `addrLo[4:0]`, and when several writes occur the last one is kept.
- R4: A captured code takes effect only in the cycle in which `sleepN` is sampled high again. Until then the outputs reflect the old register.
- R5: Register fields are as follows. Bit 4 = 0 arms deep power down (default 1, disarmed). Bit 3 = 1 selects reduced memory size (default 0, partial refresh). Bit 2 = 1 selects the top half (default 0, bottom). Bits 1:0 select the area: 00 full, 01 reserved, 10 half, 11 quarter.
- R6: The windows for a 20-bit address are 00000h-FFFFFh full, 00000h-7FFFFh bottom half, 80000h-FFFFFh top half, 00000h-3FFFFh bottom quarter, and C0000h-FFFFFh top quarter.
- R7: In reduced memory size mode the selected window is reported at all times. In partial refresh mode it is reported only in the low-power state, and at other times the window is full.
- R8: If `sleepN` falls with no register write in that cycle and none in the next ZZWE_US*CLK_PER_US-1 cycles, the block enters low power at the ZZWE_US*CLK_PER_US-th clock edge after the fall. It enters deep power down if bit 4 is 0, and partial or reduced retention otherwise.
- R9: In deep power down `deepPd` is 1 and `dataRetained` is 0. When `sleepN` is sampled high, the register reverts to default (code 10000b) and `busy` is high for RECOV_US*CLK_PER_US cycles. `dataRetained` returns to 1 when `busy` falls.
- R10: Leaving low power after `sleepN` was low for fewer than ZZMIN_US*CLK_PER_US cycles sets `protoErr`.
- R11: Area code 01 behaves as full array, and committing it sets the sticky `rsvdWarn`.
- R12: Writes with `sleepN` high, or writes that begin after low power has been entered, do not change the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rstN | input | 1 | Active-low reset, equivalent to power applied |
| chipSelN | input | 1 | Active-low chip select |
| wrEnN | input | 1 | Active-low write enable |
| hiByteN | input | 1 | Active-low upper byte enable |
| loByteN | input | 1 | Active-low lower byte enable |
| sleepN | input | 1 | Active-low low-power pin |
| addrLo | input | 5 | Low address pins carrying the register code |
| winStart | output | ADDR_W | First word address of the retained window |
| winEnd | output | ADDR_W | Last word address of the retained window |
| dataRetained | output | 1 | Contents within the window are valid |
| deepPd | output | 1 | Deep power down active |
| busy | output | 1 | Power-up wait or deep power down recovery |
| protoErr | output | 1 | Sticky protocol violation |
| rsvdWarn | output | 1 | Sticky reserved area code committed |

## Verification
Every output is registered one edge behind the sampled pins. A commit, a mode entry or a deep power down exit is visible right after the edge that samples the deciding pin level. Mode entry lands exactly ZZWE_US*CLK_PER_US edges after the edge that saw `sleepN` low. Busy lasts a fixed count of edges, and the bench checks it at count-1 and at count. The bench drives and samples only on falling clock edges and counts those edges, so each check lands at the first edge where the result is due and at the one just before it.

// File: rtl/lp_mode_pkg.sv
package lp_mode_pkg;

  localparam int CODE_W = 5;

  typedef struct packed {
    logic       dpdOff;   // 0 arms deep power down
    logic       rmsSel;   // 1 = reduced memory size
    logic       topHalf;  // 1 = upper part of the array
    logic [1:0] area;
  } mode_t;

  localparam logic [1:0] AREA_FULL = 2'b00;
  localparam logic [1:0] AREA_RSVD = 2'b01;
  localparam logic [1:0] AREA_HALF = 2'b10;
  localparam logic [1:0] AREA_QTR  = 2'b11;

  localparam mode_t MODE_DEFAULT = '{dpdOff: 1'b1, rmsSel: 1'b0, topHalf: 1'b0, area: AREA_FULL};

  typedef struct packed {
    logic capture;  // load pending code from address pins
    logic commit;   // pending -> active register
    logic revert;   // active register -> default
  } strobe_t;

  typedef enum logic [2:0] {
    ST_PWRUP, ST_IDLE, ST_ZZWAIT, ST_REGWR, ST_LOWPWR, ST_DPD, ST_RECOVER
  } state_t;

endpackage

// File: rtl/lp_mode_ctrl_fsm.sv
module lp_mode_ctrl_fsm
  import lp_mode_pkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int PWRUP_US   = 150,
  parameter int RECOV_US   = 150,
  parameter int ZZWE_US    = 1,
  parameter int ZZMIN_US   = 10
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    chipSelN,
  input  logic    wrEnN,
  input  logic    hiByteN,
  input  logic    loByteN,
  input  logic    sleepN,
  input  logic    dpdOff,
  output strobe_t stb,
  output logic    inLowPwr,
  output logic    deepPd,
  output logic    busy,
  output logic    dataRetained,
  output logic    protoErr
);

  localparam int PWR_CYC   = PWRUP_US * CLK_PER_US;
  localparam int RECOV_CYC = RECOV_US * CLK_PER_US;
  localparam int ZZWE_CYC  = ZZWE_US * CLK_PER_US;
  localparam int ZZMIN_CYC = ZZMIN_US * CLK_PER_US;
  localparam int MAX_A     = (PWR_CYC > RECOV_CYC) ? PWR_CYC : RECOV_CYC;
  localparam int MAX_CYC   = (MAX_A > ZZMIN_CYC) ? MAX_A : ZZMIN_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] PWR_LAST   = CNT_W'(PWR_CYC - 1);
  localparam logic [CNT_W-1:0] RECOV_LAST = CNT_W'(RECOV_CYC - 1);
  localparam logic [CNT_W-1:0] ZZWE_LAST  = CNT_W'(ZZWE_CYC - 1);
  localparam logic [CNT_W-1:0] ZZMIN_LAST = CNT_W'(ZZMIN_CYC - 1);
  localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

  state_t          st, stNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic            errSet, access, wrReq;

  assign access = !chipSelN && (!hiByteN || !loByteN);
  assign wrReq  = access && !wrEnN;

  always_comb begin
    stNext  = st;
    cntNext = cnt;
    stb     = '0;
    errSet  = 1'b0;
    case (st)
      ST_PWRUP: begin
        if (access || !sleepN) errSet = 1'b1;
        if (cnt == PWR_LAST) begin
          stNext  = ST_IDLE;
          cntNext = '0;
        end else begin
          cntNext = cnt + ONE;
        end
      end
      ST_IDLE: begin
        if (!sleepN) begin
          cntNext = '0;
          if (wrReq) begin
            stNext      = ST_REGWR;
            stb.capture = 1'b1;
          end else begin
            stNext = ST_ZZWAIT;
          end
        end
      end
      ST_ZZWAIT: begin
        if (sleepN) begin
          stNext = ST_IDLE;
        end else if (wrReq) begin
          stNext      = ST_REGWR;
          stb.capture = 1'b1;
        end else if (cnt == ZZWE_LAST) begin
          stNext  = dpdOff ? ST_LOWPWR : ST_DPD;
          cntNext = cnt + ONE;
        end else begin
          cntNext = cnt + ONE;
        end
      end
      ST_REGWR: begin
        if (sleepN) begin
          stb.commit = 1'b1;
          stNext     = ST_IDLE;
        end else if (wrReq) begin
          stb.capture = 1'b1;
        end
      end
      ST_LOWPWR, ST_DPD: begin
        if (sleepN) begin
          if (cnt < ZZMIN_LAST) errSet = 1'b1;
          cntNext = '0;
          if (st == ST_DPD) begin
            stNext     = ST_RECOVER;
            stb.revert = 1'b1;
          end else begin
            stNext = ST_IDLE;
          end
        end else if (cnt < ZZMIN_LAST) begin
          cntNext = cnt + ONE;
        end
      end
      ST_RECOVER: begin
        if (access || !sleepN) errSet = 1'b1;
        if (cnt == RECOV_LAST) begin
          stNext  = ST_IDLE;
          cntNext = '0;
        end else begin
          cntNext = cnt + ONE;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_PWRUP;
      cnt      <= '0;
      protoErr <= 1'b0;
    end else begin
      st  <= stNext;
      cnt <= cntNext;
      if (errSet) protoErr <= 1'b1;
    end
  end

  assign inLowPwr     = (st == ST_LOWPWR);
  assign deepPd       = (st == ST_DPD);
  assign busy         = (st == ST_PWRUP) || (st == ST_RECOVER);
  assign dataRetained = !((st == ST_DPD) || (st == ST_RECOVER));

endmodule

// File: rtl/lp_mode_ctrl_dp.sv
module lp_mode_ctrl_dp
  import lp_mode_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [CODE_W-1:0] regCode,
  input  logic              inLowPwr,
  output logic              dpdOff,
  output logic [ADDR_W-1:0] winStart,
  output logic [ADDR_W-1:0] winEnd,
  output logic              rsvdWarn
);

  localparam logic [ADDR_W-1:0] ALL_ONES  = '1;
  localparam logic [ADDR_W-1:0] HALF_SPAN = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] QTR_SPAN  = ADDR_W'(1) << (ADDR_W - 2);

  mode_t       modeQ, pendQ;
  logic        winSel;
  logic [ADDR_W-1:0] span;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= MODE_DEFAULT;
      pendQ    <= MODE_DEFAULT;
      rsvdWarn <= 1'b0;
    end else begin
      if (stb.capture) pendQ <= mode_t'(regCode);
      if (stb.commit) begin
        modeQ <= pendQ;
        if (pendQ.area == AREA_RSVD) rsvdWarn <= 1'b1;
      end
      if (stb.revert) modeQ <= MODE_DEFAULT;
    end
  end

  assign winSel = modeQ.rmsSel || inLowPwr;
  assign dpdOff = modeQ.dpdOff;

  always_comb begin
    winStart = '0;
    winEnd   = ALL_ONES;
    span     = (modeQ.area == AREA_QTR) ? QTR_SPAN : HALF_SPAN;
    if (winSel && (modeQ.area == AREA_HALF || modeQ.area == AREA_QTR)) begin
      if (modeQ.topHalf) begin
        winStart = ALL_ONES - span + ADDR_W'(1);
      end else begin
        winEnd = span - ADDR_W'(1);
      end
    end
  end

endmodule

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl
  import lp_mode_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int CLK_PER_US = 50,
  parameter int PWRUP_US   = 150,
  parameter int RECOV_US   = 150,
  parameter int ZZWE_US    = 1,
  parameter int ZZMIN_US   = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSelN,
  input  logic              wrEnN,
  input  logic              hiByteN,
  input  logic              loByteN,
  input  logic              sleepN,
  input  logic [4:0]        addrLo,
  output logic [ADDR_W-1:0] winStart,
  output logic [ADDR_W-1:0] winEnd,
  output logic              dataRetained,
  output logic              deepPd,
  output logic              busy,
  output logic              protoErr,
  output logic              rsvdWarn
);

  strobe_t stb;
  logic    inLowPwr, dpdOff;

  lp_mode_ctrl_fsm #(
    .CLK_PER_US(CLK_PER_US), .PWRUP_US(PWRUP_US), .RECOV_US(RECOV_US),
    .ZZWE_US(ZZWE_US), .ZZMIN_US(ZZMIN_US)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .wrEnN(wrEnN),
    .hiByteN(hiByteN), .loByteN(loByteN), .sleepN(sleepN), .dpdOff(dpdOff),
    .stb(stb), .inLowPwr(inLowPwr), .deepPd(deepPd), .busy(busy),
    .dataRetained(dataRetained), .protoErr(protoErr)
  );

  lp_mode_ctrl_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regCode(addrLo), .inLowPwr(inLowPwr),
    .dpdOff(dpdOff), .winStart(winStart), .winEnd(winEnd), .rsvdWarn(rsvdWarn)
  );

endmodule

// File: rtl/lp_mode_ctrl_chk.sv
module lp_mode_ctrl_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              sleepN,
  input logic [ADDR_W-1:0] winStart,
  input logic [ADDR_W-1:0] winEnd,
  input logic              dataRetained,
  input logic              deepPd,
  input logic              busy,
  input logic              protoErr,
  input logic              rsvdWarn
);

  p_dpd_not_retained_r9: assert property (@(posedge clk) disable iff (!rstN)
    deepPd |-> !dataRetained);

  p_dpd_exit_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(deepPd) |-> busy);

  p_dpd_exit_default_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(deepPd) |-> (winStart == '0 && winEnd == '1));

  p_dpd_leaves_on_wake_r9: assert property (@(posedge clk) disable iff (!rstN)
    (deepPd && sleepN) |=> !deepPd);

  p_busy_sleep_err_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !sleepN) |=> protoErr);

  p_err_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

  p_warn_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    rsvdWarn |=> rsvdWarn);

  p_win_ordered_r6: assert property (@(posedge clk) disable iff (!rstN)
    winStart <= winEnd);

endmodule

bind lp_mode_ctrl lp_mode_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .sleepN(sleepN), .winStart(winStart), .winEnd(winEnd),
  .dataRetained(dataRetained), .deepPd(deepPd), .busy(busy),
  .protoErr(protoErr), .rsvdWarn(rsvdWarn)
);

// File: tb/lp_mode_ctrl_bench.sv
module lp_mode_ctrl_bench;

  localparam int AW    = 20;
  localparam int CPU   = 2;
  localparam int PWR   = 150 * CPU;
  localparam int RECOV = 150 * CPU;
  localparam int ZZWE  = 1 * CPU;
  localparam int ZZMIN = 10 * CPU;
  localparam logic [AW-1:0] FULL = '1;

  logic clk = 1'b0, rstN = 1'b0;
  logic chipSelN = 1'b1, wrEnN = 1'b1, hiByteN = 1'b1, loByteN = 1'b1, sleepN = 1'b1;
  logic [4:0] addrLo = '0;
  logic [AW-1:0] winStart, winEnd;
  logic dataRetained, deepPd, busy, protoErr, rsvdWarn;
  int total = 0, bad = 0;
  logic warnExp = 1'b0;

  always #10 clk = ~clk;

  lp_mode_ctrl #(.ADDR_W(AW), .CLK_PER_US(CPU)) u_lp_mode_ctrl (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .wrEnN(wrEnN), .hiByteN(hiByteN),
    .loByteN(loByteN), .sleepN(sleepN), .addrLo(addrLo), .winStart(winStart),
    .winEnd(winEnd), .dataRetained(dataRetained), .deepPd(deepPd), .busy(busy),
    .protoErr(protoErr), .rsvdWarn(rsvdWarn)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] spanOf(input logic [4:0] code);
    return (code[1:0] == 2'b11) ? (AW'(1) << (AW - 2)) : (AW'(1) << (AW - 1));
  endfunction

  function automatic logic [AW-1:0] expStart(input logic [4:0] code, input logic low);
    if (!(code[3] || low) || code[1:0] < 2'd2) return '0;
    return code[2] ? (AW'(0) - spanOf(code)) : '0;
  endfunction

  function automatic logic [AW-1:0] expEnd(input logic [4:0] code, input logic low);
    if (!(code[3] || low) || code[1:0] < 2'd2) return FULL;
    return code[2] ? FULL : spanOf(code) - AW'(1);
  endfunction

  task automatic chkWin(input string req, input logic [4:0] code, input logic low);
    chk(req, 32'(winStart), 32'(expStart(code, low)));
    chk(req, 32'(winEnd), 32'(expEnd(code, low)));
  endtask

  task automatic doReset;
    rstN = 1'b0;
    cyc(3);
    rstN = 1'b1;
    warnExp = 1'b0;
  endtask

  task automatic regWrite(input logic [4:0] code);
    sleepN = 1'b0; chipSelN = 1'b0; wrEnN = 1'b0; loByteN = 1'b0; addrLo = code;
    cyc(1);
    chipSelN = 1'b1; wrEnN = 1'b1; loByteN = 1'b1; addrLo = ~code;
    cyc(1);
    sleepN = 1'b1;
    cyc(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1-chain actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(2);
    doReset();
    // R1 reset state and power-up wait
    chk("R1 busy at reset", busy, 1);
    chkWin("R1 window at reset", 5'b10000, 1'b0);
    chk("R1 retained at reset", dataRetained, 1);
    chk("R1 deepPd at reset", deepPd, 0);
    chk("R1 warn at reset", rsvdWarn, 0);
    cyc(PWR - 1);
    chk("R1 busy before end", busy, 1);
    cyc(1);
    chk("R1 busy after end", busy, 0);
    chk("R1 no error", protoErr, 0);

    // R3 / R4: write one cycle after the fall, two writes, last one kept
    sleepN = 1'b0;
    cyc(1);
    chipSelN = 1'b0; wrEnN = 1'b0; hiByteN = 1'b0; addrLo = 5'h1A;
    cyc(1);
    addrLo = 5'h1F;
    cyc(1);
    chipSelN = 1'b1; wrEnN = 1'b1; hiByteN = 1'b1;
    chkWin("R4 no effect before rise", 5'h10, 1'b0);
    sleepN = 1'b1;
    cyc(1);
    chkWin("R3 last write committed", 5'h1F, 1'b0);

    // R5 R6 R7 R8 R9 R11: sweep every code
    for (int c = 0; c < 32; c++) begin
      logic [4:0] code;
      code = 5'(c);
      regWrite(code);
      if (code[1:0] == 2'b01) warnExp = 1'b1;
      chkWin("R7 standby window", code, 1'b0);
      chk("R11 warn flag", rsvdWarn, warnExp);
      sleepN = 1'b0;
      cyc(ZZWE);
      chk("R8 not yet entered", deepPd, 0);
      chkWin("R8 window before entry", code, 1'b0);
      cyc(1);
      chk("R8 deep power down entry", deepPd, !code[4]);
      chk("R9 retained flag in low power", dataRetained, code[4]);
      chkWin("R6 low-power window", code, code[4]);
      cyc(ZZMIN);
      sleepN = 1'b1;
      cyc(1);
      if (!code[4]) begin
        chk("R9 busy after exit", busy, 1);
        chk("R9 deepPd cleared", deepPd, 0);
        chkWin("R9 register reverted", 5'h10, 1'b0);
        cyc(RECOV - 1);
        chk("R9 busy before recovery end", busy, 1);
        chk("R9 not retained in recovery", dataRetained, 0);
        cyc(1);
        chk("R9 busy after recovery end", busy, 0);
        chk("R9 retained after recovery", dataRetained, 1);
      end else begin
        chk("R7 no busy after wake", busy, 0);
        chkWin("R7 window after wake", code, 1'b0);
      end
      chk("R10 no error in sweep", protoErr, 0);
    end

    // R12: writes outside the qualifying window
    regWrite(5'h10);
    chipSelN = 1'b0; wrEnN = 1'b0; loByteN = 1'b0; addrLo = 5'h1B;
    cyc(1);
    chipSelN = 1'b1; wrEnN = 1'b1; loByteN = 1'b1;
    cyc(1);
    chkWin("R12 write with pin high ignored", 5'h10, 1'b0);
    sleepN = 1'b0;
    cyc(ZZWE + 1);
    chipSelN = 1'b0; wrEnN = 1'b0; loByteN = 1'b0; addrLo = 5'h1B;
    cyc(1);
    chipSelN = 1'b1; wrEnN = 1'b1; loByteN = 1'b1;
    cyc(ZZMIN);
    sleepN = 1'b1;
    cyc(1);
    chkWin("R12 late write ignored", 5'h10, 1'b0);
    chk("R12 no error", protoErr, 0);

    // R10: low time too short
    sleepN = 1'b0;
    cyc(ZZWE + 1);
    chk("R10 low-power entered", dataRetained, 1);
    cyc(3);
    sleepN = 1'b1;
    cyc(1);
    chk("R10 short low time flagged", protoErr, 1);

    // R2: access during power-up
    doReset();
    chk("R2 error clear after reset", protoErr, 0);
    cyc(5);
    chipSelN = 1'b0; loByteN = 1'b0;
    cyc(1);
    chipSelN = 1'b1; loByteN = 1'b1;
    chk("R2 access while busy flagged", protoErr, 1);
    cyc(3);
    chk("R2 error sticky", protoErr, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule